// File: doc/BRIEF.md
# Differential Line Direction Controller

This block sits between a two-channel serial communication controller and the differential line transceivers of each channel. A single 12-bit configuration register decides, for every channel, whether the data driver and the transmit-clock driver follow the controller's RTS output or stay on all the time. It also decides whether received data is blanked while the channel is sending, so that a half-duplex two-wire bus does not echo the station's own frames back into its receiver. The same register can force CTS active towards the controller and chooses where the internal transmit clock goes.

The block also applies the fixed polarity changes the connector standard needs. The transmit clock arriving from the line is inverted before it reaches the controller, because the line presents data on the rising edge and the controller samples on the falling edge. Carrier detect is inverted, because the line marks carrier with a low level and the controller expects a high level.

The driver enables are registered, so a change on RTS reaches the transceivers one clock later. All other paths are combinational. The register is written through a simple write strobe and is always visible on the read-back port.

Top module: `rs485_line_ctrl`

## Requirements
- R1: After reset the configuration register reads 0. A write with `cfg_we` high loads `cfg_wdata`, and `cfg_rdata` shows the new value from the next clock.
- R2: Channel c uses register bit 4c as the echo control. With that bit at 0 and `rts_i[c]` high, `rxd_o[c]` is held at 1 (idle). Otherwise `rxd_o[c]` equals `rd_line_i[c]`.
- R3: Channel c uses bit 4c+1 as the data driver control. After each clock edge, `sd_oe_o[c]` equals the OR of `rts_i[c]` and that bit as they stood before the edge, so it drops within one cycle of RTS falling. `sd_line_o[c]` always equals `txd_i[c]`.
- R4: Channel c uses bit 4c+2 as the transmit-clock driver control. After each clock edge, `tt_oe_o[c]` equals the OR of `rts_i[c]` and that bit as they stood before the edge.
- R5: Channel c uses bit 4c+3 as the CTS select. With that bit at 0, `cts_o[c]` is 1. With that bit at 1, `cts_o[c]` equals `cts_line_i[c]`.
- R6: Channel c uses bit 8+2c as the ST link. With that bit at 0, `txclk_o[c]` equals `txclk_i[c]`. With that bit at 1, `txclk_o[c]` is the inverse of `st_line_i[c]`.
- R7: `dcd_o[c]` is always the inverse of `dcd_line_i[c]`.
- R8: Channel c uses bit 9+2c as the TT link. With that bit at 0, `tt_line_o[c]` equals `txclk_i[c]`. With that bit at 1, `tt_line_o[c]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 12 | Register write data |
| cfg_rdata | output | 12 | Register read-back |
| rts_i | input | 2 | RTS from the controller, per channel |
| txd_i | input | 2 | Transmit data from the controller |
| txclk_i | input | 2 | Internal transmit clock |
| rd_line_i | input | 2 | Received data from the line |
| cts_line_i | input | 2 | CTS from the line |
| dcd_line_i | input | 2 | Carrier detect from the line, active low |
| st_line_i | input | 2 | Transmit clock from the line |
| sd_line_o | output | 2 | Data to the line driver |
| sd_oe_o | output | 2 | Data driver enable |
| tt_line_o | output | 2 | Transmit clock to the line driver |
| tt_oe_o | output | 2 | Transmit-clock driver enable |
| rxd_o | output | 2 | Received data to the controller |
| cts_o | output | 2 | CTS to the controller |
| dcd_o | output | 2 | Carrier detect to the controller, active high |
| txclk_o | output | 2 | Transmit clock to the controller |

## Verification
The hardest case to reach is RTS falling on the same edge as a register write that changes a driver control bit. In that case the enable must follow the old bit for one cycle and the new bit after that. The stimulus reaches it by randomizing RTS and the write strobe on every cycle, with long runs of random configuration values. A behavioural model that keeps its own previous-cycle state flags any cycle where the enable follows the wrong bit. Directed phases then hold each control bit at 0 and then at 1 while RTS toggles, so that echo blanking and the forced CTS are each checked on both channels.

// File: rtl/rs485_line_ctrl.sv
module rs485_line_ctrl #(
  parameter int NCH = 2,
  localparam int CW = 6 * NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CW-1:0]  cfg_wdata,
  output logic [CW-1:0]  cfg_rdata,
  input  logic [NCH-1:0] rts_i,
  input  logic [NCH-1:0] txd_i,
  input  logic [NCH-1:0] txclk_i,
  input  logic [NCH-1:0] rd_line_i,
  input  logic [NCH-1:0] cts_line_i,
  input  logic [NCH-1:0] dcd_line_i,
  input  logic [NCH-1:0] st_line_i,
  output logic [NCH-1:0] sd_line_o,
  output logic [NCH-1:0] sd_oe_o,
  output logic [NCH-1:0] tt_line_o,
  output logic [NCH-1:0] tt_oe_o,
  output logic [NCH-1:0] rxd_o,
  output logic [NCH-1:0] cts_o,
  output logic [NCH-1:0] dcd_o,
  output logic [NCH-1:0] txclk_o
);
  localparam int LINK0 = 4 * NCH;

  logic [CW-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;

  assign cfg_rdata = cfg_q;
  assign sd_line_o = txd_i;
  assign dcd_o     = ~dcd_line_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic echo_on, sd_on, tt_on, cts_pass, st_cut, tt_cut;
    assign echo_on  = cfg_q[4*c];
    assign sd_on    = cfg_q[4*c+1];
    assign tt_on    = cfg_q[4*c+2];
    assign cts_pass = cfg_q[4*c+3];
    assign st_cut   = cfg_q[LINK0+2*c];
    assign tt_cut   = cfg_q[LINK0+2*c+1];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sd_oe_o[c] <= 1'b0;
        tt_oe_o[c] <= 1'b0;
      end else begin
        sd_oe_o[c] <= rts_i[c] | sd_on;
        tt_oe_o[c] <= rts_i[c] | tt_on;
      end

    assign rxd_o[c]     = (echo_on | ~rts_i[c]) ? rd_line_i[c] : 1'b1;
    assign cts_o[c]     = cts_pass ? cts_line_i[c] : 1'b1;
    assign txclk_o[c]   = st_cut ? ~st_line_i[c] : txclk_i[c];
    assign tt_line_o[c] = tt_cut ? 1'b0 : txclk_i[c];
  end
endmodule

// File: rtl/rs485_line_ctrl_chk.sv
module rs485_line_ctrl_chk #(
  parameter int NCH = 2,
  localparam int CW = 6 * NCH
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic [CW-1:0]  cfg_wdata,
  input logic [CW-1:0]  cfg_rdata,
  input logic [NCH-1:0] rts_i,
  input logic [NCH-1:0] rd_line_i,
  input logic [NCH-1:0] dcd_line_i,
  input logic [NCH-1:0] sd_oe_o,
  input logic [NCH-1:0] tt_oe_o,
  input logic [NCH-1:0] rxd_o,
  input logic [NCH-1:0] cts_o,
  input logic [NCH-1:0] dcd_o
);
  p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_echo_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rts_i[c] && !cfg_rdata[4*c]) |-> rxd_o[c]);
    p_echo_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rts_i[c] |-> rxd_o[c] == rd_line_i[c]);
    p_sd_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rts_i[c] && !cfg_rdata[4*c+1]) |=> !sd_oe_o[c]);
    p_sd_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rts_i[c] |=> sd_oe_o[c]);
    p_tt_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rts_i[c] && !cfg_rdata[4*c+2]) |=> !tt_oe_o[c]);
    p_cts_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[4*c+3] |-> cts_o[c]);
    p_dcd_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dcd_o[c] != dcd_line_i[c]);
  end
endmodule

bind rs485_line_ctrl rs485_line_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .rts_i(rts_i), .rd_line_i(rd_line_i),
  .dcd_line_i(dcd_line_i), .sd_oe_o(sd_oe_o), .tt_oe_o(tt_oe_o),
  .rxd_o(rxd_o), .cts_o(cts_o), .dcd_o(dcd_o)
);

// File: tb/rs485_line_ctrl_tb.sv
module rs485_line_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int CW = 6 * NCH;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [CW-1:0] cfg_wdata = '0, cfg_rdata;
  logic [NCH-1:0] rts_i = '0, txd_i = '0, txclk_i = '0, rd_line_i = '0;
  logic [NCH-1:0] cts_line_i = '0, dcd_line_i = '0, st_line_i = '0;
  logic [NCH-1:0] sd_line_o, sd_oe_o, tt_line_o, tt_oe_o, rxd_o, cts_o, dcd_o, txclk_o;

  int n_chk = 0, n_fail = 0;
  logic [CW-1:0] m_cfg = '0;
  logic [NCH-1:0] m_sd = '0, m_tt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_line_ctrl #(.NCH(NCH)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 readback", cfg_rdata, m_cfg);
    chk("R3 sd_oe", sd_oe_o, m_sd);
    chk("R4 tt_oe", tt_oe_o, m_tt);
    chk("R3 sd_line", sd_line_o, txd_i);
    chk("R7 dcd", dcd_o, ~dcd_line_i & 2'b11);
    for (int c = 0; c < NCH; c++) begin
      chk("R2 rxd", rxd_o[c], (m_cfg[4*c] || !rts_i[c]) ? rd_line_i[c] : 1);
      chk("R5 cts", cts_o[c], m_cfg[4*c+3] ? cts_line_i[c] : 1);
      chk("R6 txclk", txclk_o[c], m_cfg[8+2*c] ? !st_line_i[c] : txclk_i[c]);
      chk("R8 tt_line", tt_line_o[c], m_cfg[9+2*c] ? 0 : txclk_i[c]);
    end
  endtask

  // one cycle: update model at edge from inputs held before it, then drive, then compare
  task automatic cycle(input logic we, input logic [CW-1:0] wd, input logic [NCH-1:0] rts,
                       input bit rnd);
    @(posedge clk);
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_sd[c] = rts_i[c] | m_cfg[4*c+1];
        m_tt[c] = rts_i[c] | m_cfg[4*c+2];
      end
      if (cfg_we) m_cfg = cfg_wdata;
    end
    #1;
    cfg_we = we; cfg_wdata = wd; rts_i = rts;
    if (rnd) begin
      txd_i = NCH'($urandom); txclk_i = NCH'($urandom); rd_line_i = NCH'($urandom);
      cts_line_i = NCH'($urandom); dcd_line_i = NCH'($urandom); st_line_i = NCH'($urandom);
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset cfg", cfg_rdata, 0);
        chk("R3 reset sd_oe", sd_oe_o, 0);
        chk("R4 reset tt_oe", tt_oe_o, 0);
        rst_n = 1'b1;
        // R5/R2 defaults: cts forced, echo blanked with RTS
        rd_line_i = 2'b00; cts_line_i = 2'b00;
        cycle(0, '0, 2'b11, 0);
        chk("R2 echo blanked", rxd_o, 2'b11);
        chk("R5 cts forced", cts_o, 2'b11);
        cycle(0, '0, 2'b00, 0);
        chk("R3 sd_oe follows rts", sd_oe_o, 2'b11);
        cycle(0, '0, 2'b00, 0);
        chk("R3 sd_oe dropped one cycle", sd_oe_o, 2'b00);
        // each single register bit, RTS toggling
        for (int b = 0; b < CW; b++) begin
          cycle(1, CW'(1) << b, 2'b00, 1);
          for (int k = 0; k < 6; k++) cycle(0, CW'(1) << b, NCH'(k), 1);
        end
        // all-ones then back to zero
        cycle(1, '1, 2'b11, 1);
        for (int k = 0; k < 8; k++) cycle(0, '1, NCH'(k), 1);
        cycle(1, '0, 2'b11, 1);
        cycle(0, '0, 2'b00, 1);
        cycle(0, '0, 2'b00, 1);
        chk("R4 tt_oe dropped after clear", tt_oe_o, 2'b00);
        // random soak, including writes coinciding with RTS changes
        for (int i = 0; i < 4000; i++)
          cycle(($urandom % 4) == 0, CW'($urandom), NCH'($urandom), 1);
      end
      begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule